// File: doc/BRIEF.md
# Addressed Parallel-Bus Synthesizer Programming Interface

This block connects a shared 24-bit parallel control bus with a strobe line to the parallel programming port of a direct digital synthesis chip. Many boards share one bus. Each board watches the upper six address bits and compares them with its own address switches. A strobe that does not match that board's address is dropped.

When the address matches, the two low address bits choose one of four actions:
- pulse a master reset to the synthesizer;
- write one 8-bit register;
- issue an output update (optionally preceded by a register write, with a fixed lag between the two);
- only capture the data word, so that its two modulation-control bits reach their outputs.

The strobe is synchronized to the system clock and edge-detected, so each strobe edge causes exactly one action. A busy flag covers every multi-cycle sequence, and strobes that arrive while it is high are ignored.

Top module: `ddsbus_prog_if`

## Requirements
- R1: The strobe is synchronized and edge-detected. A strobe that stays high for any number of cycles causes exactly one action.
- R2: A strobe is accepted only when bus bits 23..18 equal `board_sw`. The switches are active-low: a switch that is on reads 0. A strobe that does not match causes no pulse and captures no data.
- R3: Code 00 (bus bits 17..16) captures the data word and pulses `mrst_pulse` high for RST_CYC cycles. It causes no write and no update.
- R4: Code 01 captures the data word and gives one `wr_pulse` of WR_CYC cycles, with no update. During the pulse, `reg_addr` equals data bits 5..0 and `reg_data` equals data bits 15..8.
- R5: `reg_addr` and `reg_data` are stable in the cycle before `wr_pulse` rises and in the cycle after it falls.
- R6: Code 10 with `upd_after_wr` low gives one `upd_pulse` of UPD_CYC cycles and no write. The data bits are ignored and are not captured.
- R7: Code 10 with `upd_after_wr` high captures the data word and performs a register write as in R4. It then gives an update pulse. The number of cycles with both pulses low between the fall of `wr_pulse` and the rise of `upd_pulse` is LAG_CYC+1. The two pulses never overlap.
- R8: Code 11 only captures the data word. It causes no write, no update and no reset pulse.
- R9: `fsk_out` follows captured data bit 6 when `fsk_ext_sel` is 0, and follows `fsk_ext` when it is 1. `shk_out` follows captured data bit 7 when `shk_ext_sel` is 0, and follows `shk_ext` when it is 1.
- R10: `busy` is high throughout every reset, write or update sequence. The captured word does not change while `busy` is high. A strobe edge that arrives while `busy` is high is discarded.
- R11: After reset, all pulse outputs and `busy` are low, and the captured word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_in | input | 24 | Bits 23..16 are the address, bits 15..0 are the data |
| bus_stb | input | 1 | Asynchronous bus strobe |
| board_sw | input | 6 | Board address switch levels (on reads 0) |
| upd_after_wr | input | 1 | Code 10 writes, then updates after the lag |
| fsk_ext_sel | input | 1 | 1 takes `fsk_out` from `fsk_ext` |
| shk_ext_sel | input | 1 | 1 takes `shk_out` from `shk_ext` |
| fsk_ext | input | 1 | External frequency/phase-keying control |
| shk_ext | input | 1 | External shaped-keying control |
| reg_addr | output | 6 | Synthesizer register address |
| reg_data | output | 8 | Synthesizer register value |
| wr_pulse | output | 1 | Register write strobe |
| upd_pulse | output | 1 | Output update strobe |
| mrst_pulse | output | 1 | Synthesizer master reset |
| fsk_out | output | 1 | Frequency/phase-keying/hold control |
| shk_out | output | 1 | Shaped-keying control |
| busy | output | 1 | Sequence in progress |

## Verification
Three kinds of stimulus are used.
- A sweep over all 64 register addresses, each with its own data value, shows that address and value bits reach the right outputs. It also shows that each write is a single pulse of the set width.
- A sweep over all 64 board-select values for a fixed switch setting separates the matching board from every near miss, including neighbours that differ by a single bit.
- Each function code is applied with both settings of the combined mode. This tells apart reset, write, update, write-then-update and capture-only by the pulses each one produces, the lag between them, and whether the captured word changed.

Long strobes and strobes sent while `busy` is high confirm that each edge triggers once and is then discarded.

// File: rtl/ddsbus_prog_if.sv
module ddsbus_prog_if #(
  parameter int WR_CYC      = 2,
  parameter int UPD_CYC     = 2,
  parameter int LAG_CYC     = 4,
  parameter int RST_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] bus_in,
  input  logic        bus_stb,
  input  logic [5:0]  board_sw,
  input  logic        upd_after_wr,
  input  logic        fsk_ext_sel,
  input  logic        shk_ext_sel,
  input  logic        fsk_ext,
  input  logic        shk_ext,
  output logic [5:0]  reg_addr,
  output logic [7:0]  reg_data,
  output logic        wr_pulse,
  output logic        upd_pulse,
  output logic        mrst_pulse,
  output logic        fsk_out,
  output logic        shk_out,
  output logic        busy
);
  localparam int CNT_W = $clog2(WR_CYC + UPD_CYC + LAG_CYC + RST_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WR, S_HOLD, S_LAG, S_UPD, S_RST} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             then_upd;
  logic [15:0]      word;
  logic [SYNC_STAGES:0] stb_sh;

  wire       stb_rise = stb_sh[SYNC_STAGES-1] & ~stb_sh[SYNC_STAGES];
  wire [1:0] code     = bus_in[17:16];
  wire       hit      = stb_rise && (state == S_IDLE) && (bus_in[23:18] == board_sw);
  wire       take     = hit && !(code == 2'b10 && !upd_after_wr);

  assign reg_addr   = word[5:0];
  assign reg_data   = word[15:8];
  assign fsk_out    = fsk_ext_sel ? fsk_ext : word[6];
  assign shk_out    = shk_ext_sel ? shk_ext : word[7];
  assign wr_pulse   = (state == S_WR);
  assign upd_pulse  = (state == S_UPD);
  assign mrst_pulse = (state == S_RST);
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stb_sh <= '0;
    else        stb_sh <= {stb_sh[SYNC_STAGES-1:0], bus_stb};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    word <= '0;
    else if (take) word <= bus_in[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      then_upd <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (hit) begin
          case (code)
            2'b00: begin state <= S_RST; cnt <= CNT_W'(RST_CYC - 1); end
            2'b01: begin state <= S_SETUP; then_upd <= 1'b0; end
            2'b10: if (upd_after_wr) begin
                     state <= S_SETUP; then_upd <= 1'b1;
                   end else begin
                     state <= S_UPD; cnt <= CNT_W'(UPD_CYC - 1);
                   end
            default: state <= S_IDLE;
          endcase
        end
        S_SETUP: begin state <= S_WR; cnt <= CNT_W'(WR_CYC - 1); end
        S_WR:    if (cnt == '0) state <= S_HOLD; else cnt <= cnt - 1'b1;
        S_HOLD:  if (then_upd) begin state <= S_LAG; cnt <= CNT_W'(LAG_CYC - 1); end
                 else state <= S_IDLE;
        S_LAG:   if (cnt == '0) begin state <= S_UPD; cnt <= CNT_W'(UPD_CYC - 1); end
                 else cnt <= cnt - 1'b1;
        S_UPD:   if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        S_RST:   if (cnt == '0) state <= S_IDLE; else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddsbus_prog_if_chk.sv
module ddsbus_prog_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_pulse,
  input logic       upd_pulse,
  input logic       mrst_pulse,
  input logic       busy,
  input logic [5:0] reg_addr,
  input logic [7:0] reg_data
);
  a_r3_rst_alone: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_pulse |-> !wr_pulse && !upd_pulse);
  a_r5_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_pulse) |-> $stable(reg_addr) && $stable(reg_data));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_pulse) |-> $stable(reg_addr) && $stable(reg_data));
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pulse && upd_pulse));
  a_r10_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse || upd_pulse || mrst_pulse) |-> busy);
  a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(reg_addr) && $stable(reg_data));
endmodule

bind ddsbus_prog_if ddsbus_prog_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .upd_pulse(upd_pulse),
  .mrst_pulse(mrst_pulse), .busy(busy), .reg_addr(reg_addr), .reg_data(reg_data)
);

// File: tb/sim_ddsbus_prog_if.sv
module sim_ddsbus_prog_if;
  localparam int WRC = 6, UPC = 3, LGC = 5, RSC = 3;
  localparam logic [5:0] SW = 6'b101101;

  logic clk = 0, rst_n = 0;
  logic [23:0] bus_in = '0;
  logic bus_stb = 0, upd_after_wr = 0, fsk_ext_sel = 0, shk_ext_sel = 0, fsk_ext = 0, shk_ext = 0;
  logic [5:0] reg_addr;
  logic [7:0] reg_data;
  logic wr_pulse, upd_pulse, mrst_pulse, fsk_out, shk_out, busy;

  always #5 clk = ~clk;

  ddsbus_prog_if #(.WR_CYC(WRC), .UPD_CYC(UPC), .LAG_CYC(LGC), .RST_CYC(RSC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_stb(bus_stb), .board_sw(SW),
    .upd_after_wr(upd_after_wr), .fsk_ext_sel(fsk_ext_sel), .shk_ext_sel(shk_ext_sel),
    .fsk_ext(fsk_ext), .shk_ext(shk_ext), .reg_addr(reg_addr), .reg_data(reg_data),
    .wr_pulse(wr_pulse), .upd_pulse(upd_pulse), .mrst_pulse(mrst_pulse),
    .fsk_out(fsk_out), .shk_out(shk_out), .busy(busy));

  int checks = 0, errors = 0;
  bit done = 0;
  int n_wr = 0, n_upd = 0, n_rst = 0, wcur = 0, ucur = 0, rcur = 0;
  int wr_len = 0, upd_len = 0, rst_len = 0, gap_cnt = 0, gap = 0;
  bit pwr = 0, pupd = 0, prst = 0, gap_on = 0;
  logic [5:0] seen_addr = '0;
  logic [7:0] seen_data = '0;

  always @(posedge clk) if (rst_n) begin
    if (wr_pulse) begin
      if (!pwr) n_wr++;
      wcur++; seen_addr = reg_addr; seen_data = reg_data;
    end else if (pwr) begin
      wr_len = wcur; wcur = 0; gap_on = 1; gap_cnt = 1;
    end else if (gap_on && !upd_pulse) gap_cnt++;
    if (upd_pulse) begin
      if (!pupd) begin n_upd++; if (gap_on) gap = gap_cnt; gap_on = 0; end
      ucur++;
    end else if (pupd) begin upd_len = ucur; ucur = 0; end
    if (mrst_pulse) begin if (!prst) n_rst++; rcur++; end
    else if (prst) begin rst_len = rcur; rcur = 0; end
    pwr = wr_pulse; pupd = upd_pulse; prst = mrst_pulse;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] a, input logic [15:0] d, input int hold);
    @(negedge clk); bus_in = {a, d}; bus_stb = 1;
    repeat (hold) @(negedge clk);
    bus_stb = 0;
    repeat (25) @(negedge clk);
  endtask

  initial begin
    int w0, u0c, r0;
    logic [7:0] exp_d;
    logic [5:0] exp_a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pulses", {wr_pulse, upd_pulse, mrst_pulse, busy}, 0);
    chk("R11 word", {reg_data, reg_addr}, 0);

    // R3 master reset code 00
    w0 = n_wr; u0c = n_upd;
    strobe({SW, 2'b00}, 16'h1234, 2);
    chk("R3 rst count", n_rst, 1);
    chk("R3 rst width", rst_len, RSC);
    chk("R3 no wr/upd", (n_wr - w0) + (n_upd - u0c), 0);
    chk("R3 captured", {reg_data, reg_addr}, {8'h12, 6'h34});

    // R4 sweep over all register addresses
    for (int a = 0; a < 64; a++) begin
      w0 = n_wr; u0c = n_upd;
      exp_d = 8'(a * 7 + 3);
      strobe({SW, 2'b01}, {exp_d, 2'b00, 6'(a)}, 2);
      chk("R4 one write", n_wr - w0, 1);
      chk("R4 wr width", wr_len, WRC);
      chk("R4 addr/data at write", {seen_data, seen_addr}, {exp_d, 6'(a)});
      chk("R4 no update", n_upd - u0c, 0);
    end

    // R2 board-select sweep
    exp_d = reg_data; exp_a = reg_addr;
    for (int s = 0; s < 64; s++) begin
      w0 = n_wr;
      strobe({6'(s), 2'b01}, {8'(8'hA5 ^ 8'(s)), 2'b00, 6'(s)}, 2);
      if (6'(s) == SW) begin exp_d = 8'(8'hA5 ^ 8'(s)); exp_a = 6'(s); end
      chk("R2 accept only on match", n_wr - w0, (6'(s) == SW) ? 1 : 0);
      chk("R2 capture only on match", {reg_data, reg_addr}, {exp_d, exp_a});
    end

    // R6 plain update, data ignored
    w0 = n_wr; u0c = n_upd; exp_d = reg_data; exp_a = reg_addr;
    strobe({SW, 2'b10}, 16'hFFFF, 2);
    chk("R6 one update", n_upd - u0c, 1);
    chk("R6 upd width", upd_len, UPC);
    chk("R6 no write", n_wr - w0, 0);
    chk("R6 data not captured", {reg_data, reg_addr}, {exp_d, exp_a});

    // R7 write then delayed update
    upd_after_wr = 1;
    w0 = n_wr; u0c = n_upd;
    strobe({SW, 2'b10}, {8'h5C, 2'b00, 6'h2A}, 2);
    chk("R7 one write", n_wr - w0, 1);
    chk("R7 one update", n_upd - u0c, 1);
    chk("R7 written value", {seen_data, seen_addr}, {8'h5C, 6'h2A});
    chk("R7 lag", gap, LGC + 1);
    chk("R7 upd width", upd_len, UPC);
    upd_after_wr = 0;

    // R8 capture only, R9 latched modulation bits
    w0 = n_wr; u0c = n_upd; r0 = n_rst;
    strobe({SW, 2'b11}, {8'h3C, 2'b01, 6'h11}, 2);
    chk("R8 no pulses", (n_wr - w0) + (n_upd - u0c) + (n_rst - r0), 0);
    chk("R8 captured", {reg_data, reg_addr}, {8'h3C, 6'h11});
    chk("R9 latched fsk/shk", {fsk_out, shk_out}, 2'b10);
    strobe({SW, 2'b11}, {8'hC3, 2'b10, 6'h22}, 2);
    chk("R9 latched fsk/shk swap", {fsk_out, shk_out}, 2'b01);
    fsk_ext_sel = 1; shk_ext_sel = 1; fsk_ext = 1; shk_ext = 0;
    @(negedge clk);
    chk("R9 external a", {fsk_out, shk_out}, 2'b10);
    fsk_ext = 0; shk_ext = 1;
    @(negedge clk);
    chk("R9 external b", {fsk_out, shk_out}, 2'b01);
    fsk_ext_sel = 0; shk_ext_sel = 0;
    @(negedge clk);
    chk("R9 back to latched", {fsk_out, shk_out}, 2'b01);

    // R1 long strobe gives one action
    w0 = n_wr;
    strobe({SW, 2'b01}, {8'h77, 2'b00, 6'h05}, 40);
    chk("R1 single write on long strobe", n_wr - w0, 1);

    // R10 strobe during busy is dropped
    w0 = n_wr;
    @(negedge clk); bus_in = {SW, 2'b01, 8'h9E, 2'b00, 6'h0F}; bus_stb = 1;
    for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
    chk("R10 busy seen", busy, 1);
    bus_stb = 0;
    @(negedge clk); bus_in = {SW, 2'b01, 8'h41, 2'b00, 6'h30}; bus_stb = 1;
    @(negedge clk);
    chk("R10 still busy at second edge", busy, 1);
    repeat (30) @(negedge clk);
    bus_stb = 0;
    repeat (5) @(negedge clk);
    chk("R10 only one write", n_wr - w0, 1);
    chk("R10 first word kept", {reg_data, reg_addr}, {8'h9E, 6'h0F});
    chk("R10 idle after", busy, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule